// File: doc/BRIEF.md
# Display Line Access Slot Generator

This block decides, cell by cell, when the host processor may touch video memory on a tile-based display controller. It watches a cell-clock enable, the horizontal cell counter and the blanking and display-enable levels. It issues a one-clock grant pulse for every access opportunity it hands out. The port FIFO that holds pending host transfers consumes one word per grant.

While pixels are being fetched, the generator follows a fixed cadence. Candidate opportunities are spaced a parameterised number of cells apart, starting a parameterised number of cells after the first pixel. The last candidate of every group of four is kept back for the controller's own use. With the default values this gives eighteen host grants per visible line. Two more grants on consecutive cells follow right after the last visible pixel. A small, evenly spaced set of further grants sits inside the horizontal blanking interval. When the display is switched off, or the line lies in vertical blanking, every cell enable becomes a grant.

A per-line tally of grants issued outside horizontal blanking is exposed so that the visible-line budget can be checked from outside.

Top module: `slot_grant_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `grant` is 0 and `line_grants` is 0.
- R2: `grant` is high for exactly one clock, in the clock after a cycle with `cell_en` high that qualifies; it is never high after a cycle with `cell_en` low. Gaps between cell enables do not move slot placement, because placement counts cells, not clocks.
- R3: With `display_on`=1, `vblank`=0 and `hblank`=0, candidate k (k = 0..23) lies at `hcnt` = SLOT_OFFSET + SLOT_PITCH·k. It is granted when k mod 4 is 0, 1 or 2 and withheld when k mod 4 is 3. No other visible cell is granted.
- R4: A complete visible line with the display on and outside vertical blanking yields exactly CPU_SLOTS (18) grants. `line_grants` reads 18 once the line has moved into horizontal blanking.
- R5: On a normal visible line, no grant is issued for `hcnt` < SLOT_OFFSET, so slots are not aligned to pixel 0.
- R6: On a normal line, the cells `hcnt` = ACTIVE_CELLS and ACTIVE_CELLS+1 are both granted, back to back.
- R7: On a normal line in horizontal blanking, grants are also issued at `hcnt` = ACTIVE_CELLS + HB_OFFSET + HB_PITCH·j for j = 0..HB_GRANTS-1. No other blanking cell is granted.
- R8: Whenever `display_on`=0 or `vblank`=1, every cell enable produces a grant, including a switch-off in the middle of a line.
- R9: `line_grants` restarts on the cell enable with `hcnt`=0, taking 1 or 0 depending on whether that cell is granted. It then adds one for each grant issued while `hblank`=0, and holds its value through horizontal blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cell_en | input | 1 | One-clock enable marking each display cell |
| hcnt | input | HW (7) | Cell index within the line, 0 at the first visible cell |
| hblank | input | 1 | High from cell ACTIVE_CELLS to the end of the line |
| vblank | input | 1 | High on lines outside the visible frame |
| display_on | input | 1 | Display enable; low opens every cell to the host |
| grant | output | 1 | Host access grant pulse |
| line_grants | output | TW (6) | Grants issued outside horizontal blanking since the line began |

## Verification
The bench keeps the default parameters: a 68-cell line with 52 visible cells, a slot offset of 3, a pitch of 2 and four blanking grants at a pitch of 3. Because the offset is odd and non-zero, a grant that slipped onto pixel 0 or onto even cells would be caught at once. Because the last candidate (cell 49) is a withheld one, an off-by-one in the group-of-four count changes the line total. The same lines are run with a cell enable on every clock, every third clock and at irregular gaps. Together with a vertical-blanking line and a mid-line display switch-off, this exercises placement by cell count rather than by clock.

// File: rtl/slotgen_pkg.sv
`timescale 1ns/1ps
package slotgen_pkg;

    // Which placement rule applies to the current cell.
    typedef enum logic [1:0] {
        RG_ACTIVE = 2'd0,
        RG_HBLANK = 2'd1,
        RG_OPEN   = 2'd2
    } region_e;

    // Candidates needed so that (grp-1) out of grp leave `slots` grants.
    function automatic int cand_total(input int slots, input int grp);
        if (grp > 1) return (slots * grp) / (grp - 1);
        return slots;
    endfunction

endpackage

// File: rtl/slot_cadence.sv
`timescale 1ns/1ps
// Evenly spaced slot placer: first candidate at START, then every PITCH
// enabled cells, COUNT candidates in total; optionally the last of each
// GROUP candidates is kept back.
module slot_cadence #(
    parameter int HW            = 7,
    parameter int START         = 3,
    parameter int PITCH         = 2,
    parameter int COUNT         = 24,
    parameter int GROUP         = 4,
    parameter bit WITHHOLD_LAST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cell_en,
    input  logic [HW-1:0] hcnt,
    input  logic          window,
    output logic          hit
);
    localparam int CW = $clog2(COUNT + 1);
    localparam int PW = $clog2(PITCH + 1);
    localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] ph;
        logic [GW-1:0] grp;
    } cad_t;

    cad_t s_d, s_q;
    logic line_start;

    function automatic logic held_back(input logic [GW-1:0] g);
        return WITHHOLD_LAST && (int'(g) == GROUP - 1);
    endfunction

    function automatic logic [GW-1:0] grp_next(input logic [GW-1:0] g);
        if (int'(g) == GROUP - 1) return '0;
        return g + 1'b1;
    endfunction

    assign line_start = cell_en && (hcnt == '0);

    always_comb begin
        s_d = s_q;
        hit = 1'b0;
        if (line_start) s_d.cnt = '0;
        if (cell_en && window) begin
            if (hcnt == HW'(START)) begin
                hit     = !held_back('0);
                s_d.cnt = CW'(1);
                s_d.ph  = PW'(PITCH);
                s_d.grp = grp_next('0);
            end else if (!line_start && s_q.cnt != '0 && s_q.cnt < CW'(COUNT)) begin
                if (s_q.ph == PW'(1)) begin
                    hit     = !held_back(s_q.grp);
                    s_d.cnt = s_q.cnt + 1'b1;
                    s_d.ph  = PW'(PITCH);
                    s_d.grp = grp_next(s_q.grp);
                end else begin
                    s_d.ph = s_q.ph - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: candidate index never runs past the configured count
    assert_cand_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(COUNT));

    // R3: the countdown to the next candidate stays within one pitch
    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ph <= PW'(PITCH));

endmodule

// File: rtl/slot_tally.sv
`timescale 1ns/1ps
// Per-line count of grants issued outside horizontal blanking.
module slot_tally #(
    parameter int HW = 7,
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cell_en,
    input  logic [HW-1:0] hcnt,
    input  logic          hblank,
    input  logic          grant_d,
    output logic [TW-1:0] count
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tally_t;

    tally_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (cell_en && hcnt == '0) begin
            t_d.cnt = grant_d ? TW'(1) : '0;
        end else if (grant_d && !hblank && t_q.cnt != '1) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign count = t_q.cnt;

    // R9: a line start leaves at most one grant in the tally
    assert_tally_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && hcnt == '0) |=> (count <= TW'(1)));

    // R9: away from a line start the tally holds or steps by one
    assert_tally_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cell_en && hcnt == '0) |=> (count == $past(count) || count == $past(count) + 1'b1));

    // R9: the tally never moves during horizontal blanking
    assert_tally_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank && !(cell_en && hcnt == '0)) |=> $stable(count));

endmodule

// File: rtl/slot_grant_gen.sv
`timescale 1ns/1ps
module slot_grant_gen
    import slotgen_pkg::*;
#(
    parameter int LINE_CELLS   = 68,
    parameter int ACTIVE_CELLS = 52,
    parameter int SLOT_OFFSET  = 3,
    parameter int SLOT_PITCH   = 2,
    parameter int CPU_SLOTS    = 18,
    parameter int GROUP_SIZE   = 4,
    parameter int HB_OFFSET    = 4,
    parameter int HB_PITCH     = 3,
    parameter int HB_GRANTS    = 4,
    localparam int HW          = $clog2(LINE_CELLS),
    localparam int TW          = $clog2(ACTIVE_CELLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cell_en,
    input  logic [HW-1:0] hcnt,
    input  logic          hblank,
    input  logic          vblank,
    input  logic          display_on,
    output logic          grant,
    output logic [TW-1:0] line_grants
);
    localparam int CAND_COUNT = cand_total(CPU_SLOTS, GROUP_SIZE);
    localparam int BURST_LEN  = 2;

    typedef struct packed {
        logic grant;
    } top_t;

    top_t    r_d, r_q;
    region_e region;
    logic    cad_hit, hb_hit, burst_hit;

    // Visible-line cadence, last of every group kept back.
    slot_cadence #(
        .HW(HW), .START(SLOT_OFFSET), .PITCH(SLOT_PITCH),
        .COUNT(CAND_COUNT), .GROUP(GROUP_SIZE), .WITHHOLD_LAST(1'b1)
    ) i_cad_active (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .hcnt(hcnt),
        .window(!hblank), .hit(cad_hit)
    );

    // Evenly spaced grants inside horizontal blanking, none held back.
    slot_cadence #(
        .HW(HW), .START(ACTIVE_CELLS + HB_OFFSET), .PITCH(HB_PITCH),
        .COUNT(HB_GRANTS), .GROUP(1), .WITHHOLD_LAST(1'b0)
    ) i_cad_hblank (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .hcnt(hcnt),
        .window(hblank), .hit(hb_hit)
    );

    // Full-rate burst on the first cells after the last visible pixel.
    always_comb begin
        burst_hit = 1'b0;
        for (int b = 0; b < BURST_LEN; b++) begin
            if (hcnt == HW'(ACTIVE_CELLS + b)) burst_hit = 1'b1;
        end
    end

    always_comb begin
        if (!display_on || vblank) region = RG_OPEN;
        else if (hblank)           region = RG_HBLANK;
        else                       region = RG_ACTIVE;

        r_d = r_q;
        unique case (region)
            RG_OPEN:   r_d.grant = cell_en;
            RG_HBLANK: r_d.grant = cell_en && (burst_hit || hb_hit);
            RG_ACTIVE: r_d.grant = cell_en && cad_hit;
            default:   r_d.grant = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign grant = r_q.grant;

    slot_tally #(.HW(HW), .TW(TW)) i_tally (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .hcnt(hcnt),
        .hblank(hblank), .grant_d(r_d.grant), .count(line_grants)
    );

    // R2: a grant only ever follows a cell enable
    assert_grant_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(cell_en));

    // R8: an open line grants every cell
    assert_open_every_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && (!display_on || vblank)) |=> grant);

    // R5: nothing granted before the slot offset on a normal line
    assert_no_early_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && display_on && !vblank && !hblank && hcnt < HW'(SLOT_OFFSET)) |=> !grant);

    // R6: the first blanking cell always carries a burst grant
    assert_burst_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && display_on && !vblank && hblank && hcnt == HW'(ACTIVE_CELLS)) |=> grant);

    // R6: the second blanking cell carries the other burst grant
    assert_burst_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && display_on && !vblank && hblank && hcnt == HW'(ACTIVE_CELLS + 1)) |=> grant);

endmodule

// File: tb/test_slot_grant_gen.sv
`timescale 1ns/1ps
module test_slot_grant_gen;
    localparam int LINE  = 68;
    localparam int ACT   = 52;
    localparam int OFF   = 3;
    localparam int PIT   = 2;
    localparam int SLOTS = 18;
    localparam int CAND  = 24;
    localparam int HBO   = 4;
    localparam int HBP   = 3;
    localparam int HBN   = 4;
    localparam int HW    = $clog2(LINE);
    localparam int TW    = $clog2(ACT + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cell_en = 1'b0;
    logic [HW-1:0] hcnt = '0;
    logic          hblank = 1'b0;
    logic          vblank = 1'b0;
    logic          display_on = 1'b1;
    logic          grant;
    logic [TW-1:0] line_grants;

    int total = 0;
    int bad = 0;
    bit exp_g = 0;
    int exp_c = 0;
    string exp_tag = "R1";

    always #2.5 clk = ~clk;

    slot_grant_gen #(
        .LINE_CELLS(LINE), .ACTIVE_CELLS(ACT), .SLOT_OFFSET(OFF),
        .SLOT_PITCH(PIT), .CPU_SLOTS(SLOTS), .GROUP_SIZE(4),
        .HB_OFFSET(HBO), .HB_PITCH(HBP), .HB_GRANTS(HBN)
    ) i_slot_grant_gen (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .hcnt(hcnt),
        .hblank(hblank), .vblank(vblank), .display_on(display_on),
        .grant(grant), .line_grants(line_grants)
    );

    function automatic bit model_grant(input int h, input bit hb, input bit open);
        int k;
        if (open) return 1'b1;
        if (!hb) begin
            if (h < OFF || ((h - OFF) % PIT) != 0) return 1'b0;
            k = (h - OFF) / PIT;
            return (k < CAND) && ((k % 4) != 3);
        end
        if (h == ACT || h == ACT + 1) return 1'b1;
        if (h < ACT + HBO) return 1'b0;
        k = h - ACT - HBO;
        return ((k % HBP) == 0) && ((k / HBP) < HBN);
    endfunction

    function automatic string tag_of(input int h, input bit hb, input bit open);
        if (open) return "R8";
        if (hb) return (h < ACT + 2) ? "R6" : "R7";
        if (h < OFF) return "R5";
        return "R3";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (hcnt=%0d)", req, act, exp, hcnt);
        end
    endtask

    // One clock: check last cycle's prediction, then drive the next inputs.
    task automatic tick(input bit en, input int h, input bit vb, input bit doff);
        bit hb, g;
        @(negedge clk);
        check(exp_tag, int'(grant), int'(exp_g));
        check("R9", int'(line_grants), exp_c);
        hb = (h >= ACT);
        cell_en    = en;
        hcnt       = HW'(h);
        hblank     = hb;
        vblank     = vb;
        display_on = !doff;
        g = en && model_grant(h, hb, vb || doff);
        if (en && h == 0)    exp_c = g ? 1 : 0;
        else if (g && !hb)   exp_c = exp_c + 1;
        exp_g   = g;
        exp_tag = en ? tag_of(h, hb, vb || doff) : "R2";
    endtask

    // gap: 0 none, 1 two idle clocks per cell, 2 irregular idle clocks
    task automatic run_line(input int gap, input bit vb, input int doff_from, input bit chk18);
        int idles;
        for (int h = 0; h < LINE; h++) begin
            tick(1'b1, h, vb, h >= doff_from);
            idles = (gap == 1) ? 2 : (gap == 2) ? ((h * 7 + 3) % 4) : 0;
            for (int i = 0; i < idles; i++) tick(1'b0, h, vb, h >= doff_from);
            if (chk18 && h == ACT + HBO) check("R4", int'(line_grants), SLOTS);
        end
        tick(1'b0, LINE - 1, vb, 1'b0);
        if (chk18) check("R4", int'(line_grants), SLOTS);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(grant), 0);
        check("R1", int'(line_grants), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(grant), 0);
        check("R1", int'(line_grants), 0);

        run_line(0, 1'b0, LINE + 1, 1'b1);   // R3 R5 R6 R7 dense enables
        run_line(0, 1'b0, LINE + 1, 1'b1);   // R4 second line, R9 restart
        run_line(1, 1'b0, LINE + 1, 1'b1);   // R2 sparse enables
        run_line(2, 1'b0, LINE + 1, 1'b1);   // R2 irregular gaps
        run_line(0, 1'b1, LINE + 1, 1'b0);   // R8 vertical blanking
        check("R8", int'(line_grants), ACT);
        run_line(2, 1'b0, 20, 1'b0);         // R8 switch-off mid-line
        run_line(1, 1'b0, LINE + 1, 1'b1);   // R4 recovery after open line

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule